// File: doc/BRIEF.md
# Incremental Pattern Verifier

This block watches a decoded receive stream of 8-bit characters, each tagged with a control (K) flag and qualified by a valid strobe. It checks the stream against a framed, ramping test pattern. It sits after the word aligner and the 8B/10B decoder, and it stays dormant until the aligner reports lock. The aligner should be locked to the K28.5 comma, 10-bit code 10'b0011111010. Lock is acquired automatically, so the verifier needs no enable input.

Once armed, the verifier searches for a start-of-frame character. It then compares every later character against a 256-step data ramp followed by a fixed list of ten control characters. The end-of-frame character closes that list. Two clean frames in a row finish the test. The first mismatch ends it, and so does a search that runs too long. Both outcomes are held on two status outputs until the next digital reset.

Top module: `incrBistVerifier`

## Requirements
- R1: After reset, errDetect and bistDone are low. Both stay low, and characters are not examined, until alignSync has been sampled high.
- R2: A frame is the start-of-frame character (byte 0xFB, K=1), then 256 data characters with values 0x00 up to 0xFF (K=0), then ten K=1 characters in this order: 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xDC, 0xFC, 0xF7, 0xFE, 0xFD. The last of these, 0xFD, ends the frame.
- R3: Inside a frame, a character whose byte or K flag differs from the expected one sets errDetect and bistDone high on the clock edge that samples it.
- R4: While searching, if 31 valid characters in a row are not start-of-frame, errDetect and bistDone go high on the edge that samples the 31st. A start-of-frame arriving as the 31st character is accepted.
- R5: While searching, comma characters (byte 0xBC, K=1) and any other non-start characters are skipped without error, apart from counting toward the R4 window.
- R6: bistDone goes high with errDetect low on the edge that samples the end of the second clean frame. After only one frame, both stay low and the verifier searches again with a fresh window.
- R7: Cycles with rxValid low are ignored. They neither advance the search count nor the frame position, and their contents are never compared.
- R8: Once bistDone is high, both outputs hold their values whatever the input. Only rstN restarts verification from the dormant state.
- R9: errDetect is never high while bistDone is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive character clock |
| rstN | input | 1 | Asynchronous active-low digital reset; restarts the test |
| alignSync | input | 1 | Word aligner lock indication |
| rxByte | input | 8 | Decoded character value |
| rxIsK | input | 1 | High when the character is a control character |
| rxValid | input | 1 | High when rxByte and rxIsK carry a character |
| errDetect | output | 1 | Latched failure flag |
| bistDone | output | 1 | Latched test-finished flag |

## Verification
The bench goes after the edges of the search window: 30 skipped characters followed by a start-of-frame must pass, while 31 must fail. A counter that is off by one would either reject a legal stream or let a missing frame go unnoticed. It corrupts only the K flag of a data character, to catch a comparator that checks the byte alone, and it corrupts the closing character of the second frame, to catch a design that declares success at the first frame or that skips the last position. Bubbles with junk data inside frames and inside the search expose a design that counts or compares unqualified cycles. Stimulus sent after completion and before the sync flag rises shows any leak through the latched or dormant states.

// File: rtl/bistPkg.sv
package bistPkg;

  localparam logic [7:0] SOF_CODE = 8'hFB;
  localparam int unsigned NUM_CTRL = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_BODY,
    ST_PASS,
    ST_FAIL
  } bistState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSearch;
    logic incSearch;
    logic clrPos;
    logic incPos;
    logic clrFrame;
    logic incFrame;
  } bistCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic sofSeen;
    logic charOk;
    logic searchLast;
    logic posLast;
    logic frameLast;
  } bistSts_t;

  // closing control characters of a frame, in transmission order
  function automatic logic [7:0] ctrlCode(input logic [3:0] idx);
    logic [7:0] code;
    case (idx)
      4'd0: code = 8'h1C;
      4'd1: code = 8'h3C;
      4'd2: code = 8'h5C;
      4'd3: code = 8'h7C;
      4'd4: code = 8'h9C;
      4'd5: code = 8'hDC;
      4'd6: code = 8'hFC;
      4'd7: code = 8'hF7;
      4'd8: code = 8'hFE;
      default: code = 8'hFD;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/bistDatapath.sv
module bistDatapath
  import bistPkg::*;
#(
  parameter int unsigned DATA_LEN     = 256,
  parameter int unsigned SEARCH_LIMIT = 31,
  parameter int unsigned FRAMES_REQ   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  bistCtl_t   ctl,
  input  logic [7:0] rxByte,
  input  logic       rxIsK,
  output bistSts_t   sts
);

  localparam int unsigned FRAME_LEN = DATA_LEN + NUM_CTRL;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  localparam int unsigned SEARCH_W  = $clog2(SEARCH_LIMIT + 1);
  localparam int unsigned FRAME_W   = $clog2(FRAMES_REQ + 1);

  logic [POS_W-1:0]    posCnt;
  logic [SEARCH_W-1:0] searchCnt;
  logic [FRAME_W-1:0]  frameCnt;

  logic [7:0] expByte;
  logic       expK;
  logic       inRamp;
  logic [POS_W-1:0] ctrlOfs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt    <= '0;
      searchCnt <= '0;
      frameCnt  <= '0;
    end else begin
      if (ctl.clrPos)         posCnt <= '0;
      else if (ctl.incPos)    posCnt <= posCnt + 1'b1;

      if (ctl.clrSearch)      searchCnt <= '0;
      else if (ctl.incSearch) searchCnt <= searchCnt + 1'b1;

      if (ctl.clrFrame)       frameCnt <= '0;
      else if (ctl.incFrame)  frameCnt <= frameCnt + 1'b1;
    end
  end

  // expected character at the current frame position
  always_comb begin
    inRamp  = (posCnt < POS_W'(DATA_LEN));
    ctrlOfs = posCnt - POS_W'(DATA_LEN);
    if (inRamp) begin
      expByte = 8'(posCnt);
      expK    = 1'b0;
    end else begin
      expByte = ctrlCode(4'(ctrlOfs));
      expK    = 1'b1;
    end
  end

  always_comb begin
    sts.charOk     = (rxByte == expByte) && (rxIsK == expK);
    sts.sofSeen    = rxIsK && (rxByte == SOF_CODE);
    sts.searchLast = (searchCnt == SEARCH_W'(SEARCH_LIMIT - 1));
    sts.posLast    = (posCnt == POS_W'(FRAME_LEN - 1));
    sts.frameLast  = (frameCnt == FRAME_W'(FRAMES_REQ - 1));
  end

endmodule

// File: rtl/bistControl.sv
module bistControl
  import bistPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     alignSync,
  input  logic     rxValid,
  input  bistSts_t sts,
  output bistCtl_t ctl,
  output logic     errDetect,
  output logic     bistDone
);

  bistState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (alignSync) begin
          stateNext     = ST_HUNT;
          ctl.clrSearch = 1'b1;
          ctl.clrPos    = 1'b1;
          ctl.clrFrame  = 1'b1;
        end
      end
      ST_HUNT: begin
        if (rxValid) begin
          if (sts.sofSeen) begin
            stateNext  = ST_BODY;
            ctl.clrPos = 1'b1;
          end else if (sts.searchLast) begin
            stateNext = ST_FAIL;
          end else begin
            ctl.incSearch = 1'b1;
          end
        end
      end
      ST_BODY: begin
        if (rxValid) begin
          if (!sts.charOk) begin
            stateNext = ST_FAIL;
          end else if (sts.posLast) begin
            if (sts.frameLast) begin
              stateNext = ST_PASS;
            end else begin
              stateNext     = ST_HUNT;
              ctl.clrSearch = 1'b1;
              ctl.incFrame  = 1'b1;
            end
          end else begin
            ctl.incPos = 1'b1;
          end
        end
      end
      default: stateNext = state;
    endcase
  end

  assign errDetect = (state == ST_FAIL);
  assign bistDone  = (state == ST_FAIL) || (state == ST_PASS);

endmodule

// File: rtl/incrBistVerifier.sv
module incrBistVerifier
  import bistPkg::*;
#(
  parameter int unsigned DATA_LEN     = 256,
  parameter int unsigned SEARCH_LIMIT = 31,
  parameter int unsigned FRAMES_REQ   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       alignSync,
  input  logic [7:0] rxByte,
  input  logic       rxIsK,
  input  logic       rxValid,
  output logic       errDetect,
  output logic       bistDone
);

  bistCtl_t ctl;
  bistSts_t sts;

  bistDatapath #(
    .DATA_LEN    (DATA_LEN),
    .SEARCH_LIMIT(SEARCH_LIMIT),
    .FRAMES_REQ  (FRAMES_REQ)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .rxByte(rxByte),
    .rxIsK (rxIsK),
    .sts   (sts)
  );

  bistControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .alignSync(alignSync),
    .rxValid  (rxValid),
    .sts      (sts),
    .ctl      (ctl),
    .errDetect(errDetect),
    .bistDone (bistDone)
  );

endmodule

// File: rtl/incrBistChecker.sv
module incrBistChecker (
  input logic clk,
  input logic rstN,
  input logic alignSync,
  input logic rxValid,
  input logic errDetect,
  input logic bistDone
);

  logic syncSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          syncSeen <= 1'b0;
    else if (alignSync) syncSeen <= 1'b1;
  end

  // R1: nothing finishes before lock has been seen
  p_dormant_r1: assert property (@(posedge clk) disable iff (!rstN)
    !syncSeen |-> !bistDone);

  // R9: error only together with done
  p_err_needs_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    errDetect |-> bistDone);

  // R8: finished state holds
  p_latched_r8: assert property (@(posedge clk) disable iff (!rstN)
    bistDone |=> (bistDone && $stable(errDetect)));

  // R7: completion is only ever caused by a qualified character
  p_valid_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bistDone) |-> $past(rxValid));

endmodule

bind incrBistVerifier incrBistChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .alignSync(alignSync),
  .rxValid  (rxValid),
  .errDetect(errDetect),
  .bistDone (bistDone)
);

// File: tb/sim_incrBistVerifier.sv
`timescale 1ns/1ps
module sim_incrBistVerifier;

  localparam realtime CYC = 5.0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       alignSync = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       rxIsK = 1'b0;
  logic       rxValid = 1'b0;
  logic       errDetect;
  logic       bistDone;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CYC/2) clk = ~clk;

  incrBistVerifier u0 (
    .clk      (clk),
    .rstN     (rstN),
    .alignSync(alignSync),
    .rxByte   (rxByte),
    .rxIsK    (rxIsK),
    .rxValid  (rxValid),
    .errDetect(errDetect),
    .bistDone (bistDone)
  );

  typedef struct {
    string tag;
    logic  e;
    logic  d;
  } exp_t;
  exp_t q[$];

  // reference model state: 0 idle, 1 hunt, 2 body, 3 pass, 4 fail
  int mSt = 0, mCnt = 0, mPos = 0, mFrames = 0;

  function automatic logic [7:0] refByte(input int pos);
    logic [7:0] tail [10] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C,
                              8'hDC, 8'hFC, 8'hF7, 8'hFE, 8'hFD};
    if (pos < 0)   return 8'hFB;
    if (pos < 256) return 8'(pos);
    return tail[pos-256];
  endfunction

  function automatic logic refK(input int pos);
    return (pos < 0) || (pos >= 256);
  endfunction

  task automatic compare(input string tag, input logic ae, input logic ad,
                         input logic ee, input logic ed);
    nChecks++;
    if (ae !== ee || ad !== ed) begin
      nErrors++;
      $display("FAIL %s: err/done = %b/%b, expected %b/%b", tag, ae, ad, ee, ed);
    end
  endtask

  task automatic drive(input logic s, input logic [7:0] b, input logic k,
                       input logic v, input string tag);
    exp_t x;
    @(negedge clk);
    alignSync = s; rxByte = b; rxIsK = k; rxValid = v;
    case (mSt)
      0: if (s) begin mSt = 1; mCnt = 0; mFrames = 0; end
      1: if (v) begin
           if (k && b == 8'hFB) begin mSt = 2; mPos = 0; end
           else if (mCnt == 30) mSt = 4;
           else mCnt++;
         end
      2: if (v) begin
           if (b != refByte(mPos) || k != refK(mPos)) mSt = 4;
           else if (mPos == 265) begin
             if (mFrames == 1) mSt = 3;
             else begin mFrames++; mSt = 1; mCnt = 0; end
           end else mPos++;
         end
      default: ;
    endcase
    x.tag = tag; x.e = (mSt == 4); x.d = (mSt >= 3);
    q.push_back(x);
  endtask

  // monitor: compares one expected item per cycle after the edge
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        x = q.pop_front();
        compare(x.tag, errDetect, bistDone, x.e, x.d);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; alignSync = 1'b0; rxValid = 1'b0;
    mSt = 0; mCnt = 0; mPos = 0; mFrames = 0;
    @(posedge clk); #1;
    compare("R1 reset", errDetect, bistDone, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // mode 0 clean, 1 flip byte bit, 2 flip K flag; gap>0 inserts junk bubbles
  task automatic sendFrame(input int badAt, input int mode, input int gap,
                           input string tag);
    for (int i = -1; i < 266; i++) begin
      logic [7:0] b;
      logic k;
      if (gap > 0 && (i % gap) == 0) drive(1'b1, 8'hAA, 1'b1, 1'b0, "R7 bubble");
      b = refByte(i);
      k = refK(i);
      if (i == badAt && mode == 1) b = b ^ 8'h10;
      if (i == badAt && mode == 2) k = ~k;
      drive(1'b1, b, k, 1'b1, tag);
    end
  endtask

  task automatic sendCommas(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, 8'hBC, 1'b1, 1'b1, tag);
  endtask

  initial begin
    #(CYC * 150000);
    nChecks++; nErrors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    // scenario A: dormant before lock, then two clean frames
    doReset();
    drive(1'b0, 8'hFB, 1'b1, 1'b1, "R1 pre-sync SOF");
    for (int i = 0; i < 40; i++) drive(1'b0, 8'h33, 1'b0, 1'b1, "R1 pre-sync junk");
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R1 sync rise");
    sendCommas(3, "R5 commas");
    sendFrame(-2, 0, 0, "R2 frame 1");
    sendCommas(5, "R5 inter-frame commas");
    sendFrame(-2, 0, 0, "R6 frame 2");
    for (int i = 0; i < 10; i++) drive(1'b0, 8'h12, 1'b0, 1'b1, "R8 hold pass");

    // scenario B: bubbles everywhere, including inside the search
    doReset();
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R1 sync");
    for (int i = 0; i < 30; i++) begin
      drive(1'b1, 8'hBC, 1'b1, 1'b0, "R7 hunt bubble");
      drive(1'b1, 8'hBC, 1'b1, 1'b1, "R5 comma");
    end
    sendFrame(-2, 0, 7, "R7 frame 1 gapped");
    sendFrame(-2, 0, 13, "R7 frame 2 gapped");

    // scenario C: SOF as 31st character accepted, then data byte error
    doReset();
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R1 sync");
    for (int i = 0; i < 30; i++) drive(1'b1, 8'(i), 1'b0, 1'b1, "R4 window");
    sendFrame(100, 1, 0, "R3 byte error");
    for (int i = 0; i < 5; i++) drive(1'b1, 8'hFB, 1'b1, 1'b1, "R8 hold fail");

    // scenario D: 31 non-start characters
    doReset();
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R1 sync");
    sendCommas(31, "R4 window expiry");
    drive(1'b1, 8'hFB, 1'b1, 1'b1, "R8 hold after expiry");

    // scenario E: K flag error with correct byte
    doReset();
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R1 sync");
    sendFrame(5, 2, 0, "R3 K flag error");

    // scenario F: second frame bad at last position, then restart
    doReset();
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R1 sync");
    sendFrame(-2, 0, 0, "R6 frame 1");
    sendCommas(2, "R5 commas");
    sendFrame(265, 1, 0, "R6 bad end of frame 2");
    doReset();
    drive(1'b1, 8'h00, 1'b0, 1'b0, "R8 restart sync");
    sendFrame(-2, 0, 0, "R8 restart frame 1");
    sendFrame(-2, 0, 0, "R8 restart frame 2");

    repeat (3) @(posedge clk);
    #2;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule